// File: doc/BRIEF.md
# Two-Floor Lift Controller

This block is the sequencing controller for a lift car that serves a lower and an upper floor. It watches the hall call buttons on each landing, the destination buttons inside the car, a sensor that reports the car level with each floor, and a sensor that reports the car nearing each floor. It also watches three feedback signals: door fully open, door fully shut, and the expiry of an external dwell timer. From these it commands car motion, a timer start pulse, a slow-down request, and door open and door close drives.

Each trip runs through three stages with the car parked. The doors open. A request for the other floor starts the dwell timer, and the controller waits for it to expire. The doors then close. Once they report shut, the controller picks the direction of travel from the floor sensor that is active. It drives the motor until the car reaches the target floor, asking for slow-down while the approach sensor for that floor is lit, and then parks again. The state is held one-hot and is brought out so that the surrounding logic can observe it.

Top module: `lift2_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the machine in the park state. In that state every command output is 0 except the door-open drive, which is 1 while `door_open` is 0.
- R2: The state is one-hot on `state_q`, with bit 0 = park, bit 1 = dwell, bit 2 = shut, bit 3 = descend and bit 4 = ascend. Exactly one bit is set in every cycle after reset.
- R3: In park, `door_open_cmd` equals the inverse of `door_open`.
- R4: A request is pending when the door is fully open and a button (hall or car) asks for the floor other than the one whose level sensor is lit. In park, the machine stays in park while no request is pending. When a request is pending, `tmr_start` is 1 in that cycle and the next state is dwell. `tmr_start` is 0 in every other state.
- R5: Dwell holds while `timer_done` is 0 and moves to shut on the first cycle in which `timer_done` is 1.
- R6: In shut, `door_close_cmd` is 1 when `door_shut` is 0 and either level sensor is lit. The machine stays in shut while `door_shut` is 0.
- R7: In shut with `door_shut` at 1, the next state is descend if `at_hi` is 1, or ascend if only `at_lo` is 1. With neither level sensor lit, the machine stays in shut.
- R8: Descend drives `mov_dn` at 1 and sets `slow` equal to `near_lo`. It returns to park on the clock after `at_lo` is 1.
- R9: Ascend drives `mov_up` at 1 and sets `slow` equal to `near_hi`. It returns to park on the clock after `at_hi` is 1.
- R10: `mov_up` and `mov_dn` are never 1 together. Each command output is 0 in every state that does not name it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_lo | input | 1 | Hall call button at the lower floor |
| hall_hi | input | 1 | Hall call button at the upper floor |
| car_lo | input | 1 | In-car button for the lower floor |
| car_hi | input | 1 | In-car button for the upper floor |
| at_lo | input | 1 | Car level with the lower floor |
| at_hi | input | 1 | Car level with the upper floor |
| near_lo | input | 1 | Car approaching the lower floor |
| near_hi | input | 1 | Car approaching the upper floor |
| door_open | input | 1 | Door reports fully open |
| door_shut | input | 1 | Door reports fully shut |
| timer_done | input | 1 | Dwell timer has expired |
| mov_up | output | 1 | Drive car upward |
| mov_dn | output | 1 | Drive car downward |
| tmr_start | output | 1 | Start pulse for the dwell timer |
| slow | output | 1 | Request reduced car speed |
| door_open_cmd | output | 1 | Drive doors open |
| door_close_cmd | output | 1 | Drive doors shut |
| state_q | output | 5 | One-hot state, bit order as in R2 |

## Verification
Two functions can coincide while the car is moving: the slow-down request and the arrival at a floor. The bench raises the approach sensor and the level sensor for the target floor in the same cycle during descent. It expects `slow` high and the motor still driven in that cycle, then park with both motor outputs low on the next clock. The same kind of overlap occurs in the shut state, where the door reports shut while both level sensors are lit. That cycle must stop the close drive and choose descend.

// File: rtl/lift2_pkg.sv
package lift2_pkg;
  localparam int unsigned NST = 5;
  localparam int unsigned SW  = NST;

  localparam int unsigned IX_PARK = 0;
  localparam int unsigned IX_WAIT = 1;
  localparam int unsigned IX_SHUT = 2;
  localparam int unsigned IX_DN   = 3;
  localparam int unsigned IX_UP   = 4;

  localparam logic [SW-1:0] ST_PARK = SW'(1) << IX_PARK;
  localparam logic [SW-1:0] ST_WAIT = SW'(1) << IX_WAIT;
  localparam logic [SW-1:0] ST_SHUT = SW'(1) << IX_SHUT;
  localparam logic [SW-1:0] ST_DN   = SW'(1) << IX_DN;
  localparam logic [SW-1:0] ST_UP   = SW'(1) << IX_UP;

  // A request exists when the door is open and someone wants the other floor.
  function automatic logic req_term(input logic dopen, input logic lo, input logic hi,
                                    input logic want_lo, input logic want_hi);
    return dopen & ((lo & want_hi) | (hi & want_lo));
  endfunction

  // Leave the shut state only with the door closed and a floor known.
  function automatic logic can_depart(input logic shut, input logic lo, input logic hi);
    return shut & (lo | hi);
  endfunction
endpackage

// File: rtl/lift2_next.sv
module lift2_next
  import lift2_pkg::*;
(
  input  logic [SW-1:0] st,
  input  logic          at_lo,
  input  logic          at_hi,
  input  logic          door_shut,
  input  logic          timer_done,
  input  logic          req,
  output logic [SW-1:0] nxt,
  output logic          ev_depart,
  output logic          ev_arrive
);
  logic depart_ok;
  assign depart_ok = can_depart(door_shut, at_lo, at_hi);
  assign ev_depart = st[IX_SHUT] & depart_ok;
  assign ev_arrive = (st[IX_DN] & at_lo) | (st[IX_UP] & at_hi);

  always_comb begin
    nxt = '0;
    nxt[IX_PARK] = (st[IX_PARK] & ~req) | ev_arrive;
    nxt[IX_WAIT] = (st[IX_PARK] & req) | (st[IX_WAIT] & ~timer_done);
    nxt[IX_SHUT] = (st[IX_WAIT] & timer_done) | (st[IX_SHUT] & ~depart_ok);
    nxt[IX_DN]   = (ev_depart & at_hi) | (st[IX_DN] & ~at_lo);
    nxt[IX_UP]   = (ev_depart & at_lo & ~at_hi) | (st[IX_UP] & ~at_hi);
  end
endmodule

// File: rtl/lift2_outs.sv
module lift2_outs
  import lift2_pkg::*;
(
  input  logic [SW-1:0] st,
  input  logic          req,
  input  logic          at_lo,
  input  logic          at_hi,
  input  logic          near_lo,
  input  logic          near_hi,
  input  logic          door_open,
  input  logic          door_shut,
  output logic          mov_up,
  output logic          mov_dn,
  output logic          tmr_start,
  output logic          slow,
  output logic          door_open_cmd,
  output logic          door_close_cmd
);
  always_comb begin
    mov_up         = st[IX_UP];
    mov_dn         = st[IX_DN];
    tmr_start      = st[IX_PARK] & req;
    slow           = (st[IX_DN] & near_lo) | (st[IX_UP] & near_hi);
    door_open_cmd  = st[IX_PARK] & ~door_open;
    door_close_cmd = st[IX_SHUT] & ~door_shut & (at_lo | at_hi);
  end
endmodule

// File: rtl/lift2_ctrl.sv
module lift2_ctrl
  import lift2_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          hall_lo,
  input  logic          hall_hi,
  input  logic          car_lo,
  input  logic          car_hi,
  input  logic          at_lo,
  input  logic          at_hi,
  input  logic          near_lo,
  input  logic          near_hi,
  input  logic          door_open,
  input  logic          door_shut,
  input  logic          timer_done,
  output logic          mov_up,
  output logic          mov_dn,
  output logic          tmr_start,
  output logic          slow,
  output logic          door_open_cmd,
  output logic          door_close_cmd,
  output logic [SW-1:0] state_q
);
  logic [SW-1:0] state_d;
  logic          req;
  logic          ev_depart;
  logic          ev_arrive;

  assign req = req_term(door_open, at_lo, at_hi, hall_lo | car_lo, hall_hi | car_hi);

  lift2_next u_next (
    .st(state_q), .at_lo(at_lo), .at_hi(at_hi), .door_shut(door_shut),
    .timer_done(timer_done), .req(req), .nxt(state_d),
    .ev_depart(ev_depart), .ev_arrive(ev_arrive)
  );

  lift2_outs u_outs (
    .st(state_q), .req(req), .at_lo(at_lo), .at_hi(at_hi),
    .near_lo(near_lo), .near_hi(near_hi), .door_open(door_open),
    .door_shut(door_shut), .mov_up(mov_up), .mov_dn(mov_dn),
    .tmr_start(tmr_start), .slow(slow), .door_open_cmd(door_open_cmd),
    .door_close_cmd(door_close_cmd)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_PARK;
    else     state_q <= state_d;
  end

  assert_state_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(state_q) == 1);
  assert_motion_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(mov_up && mov_dn));
  assert_tstart_to_wait_R4: assert property (@(posedge clk) disable iff (rst)
    tmr_start |=> state_q == ST_WAIT);
  assert_wait_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && !timer_done) |=> state_q == ST_WAIT);
  assert_shut_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SHUT && !door_shut) |=> state_q == ST_SHUT);
  assert_depart_hi_R7: assert property (@(posedge clk) disable iff (rst)
    (ev_depart && at_hi) |=> state_q == ST_DN);
  assert_arrive_lo_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DN && at_lo) |=> state_q == ST_PARK);
  assert_arrive_hi_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_UP && at_hi) |=> state_q == ST_PARK);
  assert_arrive_event_R8: assert property (@(posedge clk) disable iff (rst)
    ev_arrive |=> !mov_up && !mov_dn);
endmodule

// File: tb/sim_lift2_ctrl.sv
module sim_lift2_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hall_lo = 0, hall_hi = 0, car_lo = 0, car_hi = 0;
  logic at_lo = 0, at_hi = 0, near_lo = 0, near_hi = 0;
  logic door_open = 0, door_shut = 0, timer_done = 0;
  logic mov_up, mov_dn, tmr_start, slow, door_open_cmd, door_close_cmd;
  logic [4:0] state_q;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  localparam logic [4:0] P_PARK = 5'b00001;
  localparam logic [4:0] P_WAIT = 5'b00010;
  localparam logic [4:0] P_SHUT = 5'b00100;
  localparam logic [4:0] P_DN   = 5'b01000;
  localparam logic [4:0] P_UP   = 5'b10000;

  always #5 clk = ~clk;

  lift2_ctrl u0 (
    .clk(clk), .rst(rst), .hall_lo(hall_lo), .hall_hi(hall_hi), .car_lo(car_lo),
    .car_hi(car_hi), .at_lo(at_lo), .at_hi(at_hi), .near_lo(near_lo),
    .near_hi(near_hi), .door_open(door_open), .door_shut(door_shut),
    .timer_done(timer_done), .mov_up(mov_up), .mov_dn(mov_dn),
    .tmr_start(tmr_start), .slow(slow), .door_open_cmd(door_open_cmd),
    .door_close_cmd(door_close_cmd), .state_q(state_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // outputs packed as {up,dn,ts,slow,open,close}
  function automatic logic [5:0] outs();
    return {mov_up, mov_dn, tmr_start, slow, door_open_cmd, door_close_cmd};
  endfunction

  task automatic tick(); @(negedge clk); #1; endtask

  always @(negedge clk) if (!rst && !finished) begin
    chk("R2 onehot", 32'($countones(state_q)), 32'd1);
    chk("R10 motion exclusive", 32'(mov_up & mov_dn), 32'd0);
  end

  task automatic clear_in();
    hall_lo = 0; hall_hi = 0; car_lo = 0; car_hi = 0;
    near_lo = 0; near_hi = 0; timer_done = 0;
  endtask

  task automatic t_reset();
    rst = 1; tick(); tick(); rst = 0; #1;
    chk("R1 reset state", 32'(state_q), 32'(P_PARK));
    chk("R1 reset outputs", 32'(outs()), 32'b000010);
  endtask

  task automatic t_park_lo();
    at_lo = 1; door_open = 0; door_shut = 0; #1;
    chk("R3 open while not open", 32'(door_open_cmd), 32'd1);
    door_open = 1; hall_lo = 1; car_lo = 1; #1;
    chk("R3 open cmd drops", 32'(door_open_cmd), 32'd0);
    chk("R4 own-floor request ignored", 32'(tmr_start), 32'd0);
    tick();
    chk("R4 stay park", 32'(state_q), 32'(P_PARK));
    clear_in(); hall_hi = 1; #1;
    chk("R4 timer pulse", 32'(outs()), 32'b001000);
    tick();
    chk("R4 to dwell", 32'(state_q), 32'(P_WAIT));
    chk("R4 pulse single", 32'(tmr_start), 32'd0);
  endtask

  task automatic t_wait();
    clear_in();
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R5 dwell holds", 32'(state_q), 32'(P_WAIT));
    end
    chk("R10 dwell outputs", 32'(outs()), 32'd0);
    timer_done = 1; tick(); timer_done = 0; #1;
    chk("R5 to shut", 32'(state_q), 32'(P_SHUT));
  endtask

  task automatic t_shut_up();
    door_open = 0; door_shut = 0; #1;
    chk("R6 close drive", 32'(outs()), 32'b000001);
    tick();
    chk("R6 shut holds", 32'(state_q), 32'(P_SHUT));
    door_shut = 1; #1;
    chk("R6 close drive off", 32'(door_close_cmd), 32'd0);
    tick();
    chk("R7 low floor goes up", 32'(state_q), 32'(P_UP));
  endtask

  task automatic t_up();
    at_lo = 0; door_shut = 1; #1;
    chk("R9 up output", 32'(outs()), 32'b100000);
    near_hi = 1; #1;
    chk("R9 slow near top", 32'(slow), 32'd1);
    tick();
    chk("R9 still up", 32'(state_q), 32'(P_UP));
    at_hi = 1; near_hi = 0; tick();
    chk("R9 park at top", 32'(state_q), 32'(P_PARK));
    chk("R9 motor off", 32'(mov_up), 32'd0);
  endtask

  task automatic go_shut_from_hi();
    door_shut = 0; door_open = 1; car_lo = 1; tick(); car_lo = 0;
    timer_done = 1; tick(); timer_done = 0; door_open = 0; #1;
    chk("R5 reach shut from top", 32'(state_q), 32'(P_SHUT));
  endtask

  task automatic t_shut_none_and_both();
    go_shut_from_hi();
    at_hi = 0; at_lo = 0; door_shut = 1; #1;
    chk("R6 no close without floor", 32'(door_close_cmd), 32'd0);
    tick();
    chk("R7 no floor stays shut", 32'(state_q), 32'(P_SHUT));
    at_hi = 1; at_lo = 1; tick();
    chk("R7 both floors go down", 32'(state_q), 32'(P_DN));
    at_lo = 0;
  endtask

  task automatic t_down_overlap();
    at_hi = 0; #1;
    chk("R8 down output", 32'(outs()), 32'b010000);
    tick();
    chk("R8 still down", 32'(state_q), 32'(P_DN));
    near_lo = 1; at_lo = 1; #1;
    chk("R8 slow with arrival", 32'(outs()), 32'b010100);
    tick(); near_lo = 0; #1;
    chk("R8 park at bottom", 32'(state_q), 32'(P_PARK));
    chk("R8 motors off", 32'({mov_up, mov_dn}), 32'd0);
  endtask

  task automatic t_reset_mid();
    door_open = 1; car_hi = 1; tick(); car_hi = 0;
    chk("R4 to dwell again", 32'(state_q), 32'(P_WAIT));
    rst = 1; tick(); rst = 0; #1;
    chk("R1 reset from dwell", 32'(state_q), 32'(P_PARK));
  endtask

  initial begin
    tick();
    t_reset();
    t_park_lo();
    t_wait();
    t_shut_up();
    t_up();
    t_shut_none_and_both();
    t_down_overlap();
    t_reset_mid();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule